// File: doc/BRIEF.md
# Register ALU and Shift Unit

This block runs the register-to-register arithmetic, logic and shift instructions of a small machine with eight 32-bit general registers. Each cycle it can take one 16-bit instruction. The top nibble selects one of two groups. Group 6 is register arithmetic, with a sub-operation in bits [11:8]. Group 7 is the shift, with the destination in bits [11:8] and a signed 8-bit amount in bits [7:0]. The block reads the operands, computes the result and writes it into the destination register at the same clock edge. None of these instructions touches memory.

The register file is shared with the machine's load path, so the block has a separate load write port. After each instruction a registered writeback report gives the destination index and the value written, which lets the surrounding pipeline and the bench see every register update. Group-6 sub-codes that have no operation raise an illegal-instruction flag and are not executed. Every other instruction, including the group-6 code 0xF, belongs to other units and is passed by with no effect.

Top module: `reg_alu_unit`

## Requirements
- R1: After an active-low reset, every register reads zero, and `wb_valid_o` and `illegal_o` are low.
- R2: Instruction 0x60sd copies r[s] into r[d]. 0x61sd writes r[d]+r[s] to r[d]. 0x62sd writes r[d]&r[s] to r[d]. The register index is in the low 3 bits of each nibble (s in [7:4], d in [3:0]).
- R3: 0x63-d adds 1, 0x64-d adds 4, 0x65-d subtracts 1 and 0x66-d subtracts 4 from r[d]. All of these wrap modulo 2^32, and no flag is produced.
- R4: 0x67-d replaces r[d] with its bitwise complement.
- R5: 0x7dSS with SS in 1..127 (as a two's-complement value) shifts r[d] left by SS. SS=0 leaves r[d] unchanged.
- R6: 0x7dSS with SS negative shifts r[d] right logically by -SS, filling with zeros. A shift magnitude of 32 or more in either direction gives zero.
- R7: Sub-codes 0x68 to 0x6E set `illegal_o` one cycle later and write no register.
- R8: Instructions whose top nibble is neither 6 nor 7, and the 0x6F code, write no register and raise neither `wb_valid_o` nor `illegal_o`.
- R9: One cycle after an accepted instruction, `wb_valid_o` is high with `wb_idx_o` = d and `wb_data_o` = the new r[d]. A cycle with `instr_valid_i` low produces neither `wb_valid_o` nor `illegal_o` in the next cycle.
- R10: `ld_en_i` writes `ld_data_i` into r[`ld_idx_i`] at the clock edge. When an instruction writes the same register in the same cycle, the instruction's result wins. Operands are always read before either write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 16 | Instruction halfword |
| ld_en_i | input | 1 | Load path write enable |
| ld_idx_i | input | 3 | Load path destination register |
| ld_data_i | input | 32 | Load path data |
| wb_valid_o | output | 1 | A register was written by the previous instruction |
| wb_idx_o | output | 3 | Register written |
| wb_data_o | output | 32 | Value written |
| illegal_o | output | 1 | Previous instruction had an undefined group-6 sub-code |

## Verification
The bench builds the unit with its default 32-bit width and eight registers. At these values, shift amounts of 31, 32, 127 and -128 fall on both sides of the zeroing limit, and both the increment and decrement by four wrap. Because the file holds only eight registers, random instructions often reuse a destination and feed results back as operands. Load writes aimed at the same register as an instruction also occur often, so the write-priority rule gets exercised.

// File: rtl/reg_alu_pkg.sv
package reg_alu_pkg;
  typedef enum logic [3:0] {
    ALU_MOV  = 4'h0,
    ALU_ADD  = 4'h1,
    ALU_AND  = 4'h2,
    ALU_INC  = 4'h3,
    ALU_INCW = 4'h4,
    ALU_DEC  = 4'h5,
    ALU_DECW = 4'h6,
    ALU_NOT  = 4'h7
  } alu_op_e;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_ALU   = 2'd1,
    K_SHIFT = 2'd2,
    K_ILL   = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    alu_op_e    op;
    logic [3:0] rd_f;
    logic [3:0] rs_f;
    logic [7:0] amt;
  } dec_t;
endpackage

// File: rtl/reg_alu_decode.sv
module reg_alu_decode
  import reg_alu_pkg::*;
(
  input  logic        valid_i,
  input  logic [15:0] instr_i,
  output dec_t        dec_o
);
  logic [3:0] grp, sub;
  assign grp = instr_i[15:12];
  assign sub = instr_i[11:8];

  always_comb begin
    dec_o      = '0;
    dec_o.op   = ALU_MOV;
    dec_o.kind = K_NONE;
    dec_o.rs_f = instr_i[7:4];
    dec_o.rd_f = instr_i[3:0];
    dec_o.amt  = instr_i[7:0];
    if (valid_i) begin
      if (grp == 4'h6) begin
        if (sub[3] == 1'b0) begin
          dec_o.kind = K_ALU;
          dec_o.op   = alu_op_e'(sub);
        end else if (sub != 4'hF) begin
          dec_o.kind = K_ILL;
        end
      end else if (grp == 4'h7) begin
        dec_o.kind = K_SHIFT;
        dec_o.rd_f = sub;
      end
    end
  end
endmodule

// File: rtl/reg_alu_shift.sv
module reg_alu_shift #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [7:0]   amt_i,
  output logic [W-1:0] y_o
);
  logic [8:0] mag;
  assign mag = amt_i[7] ? (9'd0 - {1'b1, amt_i}) : {1'b0, amt_i};

  always_comb begin
    if (int'(mag) >= W)  y_o = '0;
    else if (amt_i[7])   y_o = a_i >> mag;
    else                 y_o = a_i << mag;
  end
endmodule

// File: rtl/reg_alu_exec.sv
module reg_alu_exec
  import reg_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] s_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] FOUR = W'(4);

  always_comb begin
    unique case (op_i)
      ALU_MOV:  y_o = s_i;
      ALU_ADD:  y_o = d_i + s_i;
      ALU_AND:  y_o = d_i & s_i;
      ALU_INC:  y_o = d_i + ONE;
      ALU_INCW: y_o = d_i + FOUR;
      ALU_DEC:  y_o = d_i - ONE;
      ALU_DECW: y_o = d_i - FOUR;
      ALU_NOT:  y_o = ~d_i;
      default:  y_o = s_i;
    endcase
  end
endmodule

// File: rtl/reg_alu_regs.sv
module reg_alu_regs #(
  parameter int W = 32,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_a_i,
  input  logic [AW-1:0] rd_b_i,
  output logic [W-1:0]  q_a_o,
  output logic [W-1:0]  q_b_o,
  input  logic          wa_en_i,
  input  logic [AW-1:0] wa_idx_i,
  input  logic [W-1:0]  wa_data_i,
  input  logic          wb_en_i,
  input  logic [AW-1:0] wb_idx_i,
  input  logic [W-1:0]  wb_data_i
);
  logic [W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem[g] <= '0;
      else if (wa_en_i && wa_idx_i == AW'(g))      mem[g] <= wa_data_i; // port a wins
      else if (wb_en_i && wb_idx_i == AW'(g))      mem[g] <= wb_data_i;
    end
  end

  assign q_a_o = mem[rd_a_i];
  assign q_b_o = mem[rd_b_i];
endmodule

// File: rtl/reg_alu_unit.sv
module reg_alu_unit
  import reg_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [15:0]       instr_i,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              illegal_o
);
  dec_t              dec;
  logic [IDX_W-1:0]  rd_idx, rs_idx;
  logic [DATA_W-1:0] d_val, s_val, alu_y, sh_y, res;
  logic              wr_en;

  reg_alu_decode u_dec (
    .valid_i(instr_valid_i), .instr_i(instr_i), .dec_o(dec)
  );

  assign rd_idx = dec.rd_f[IDX_W-1:0];
  assign rs_idx = dec.rs_f[IDX_W-1:0];

  reg_alu_regs #(.W(DATA_W), .N(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .rd_a_i(rd_idx), .rd_b_i(rs_idx),
    .q_a_o(d_val),   .q_b_o(s_val),
    .wa_en_i(wr_en), .wa_idx_i(rd_idx), .wa_data_i(res),
    .wb_en_i(ld_en_i), .wb_idx_i(ld_idx_i), .wb_data_i(ld_data_i)
  );

  reg_alu_exec #(.W(DATA_W)) u_exec (
    .op_i(dec.op), .d_i(d_val), .s_i(s_val), .y_o(alu_y)
  );

  reg_alu_shift #(.W(DATA_W)) u_shift (
    .a_i(d_val), .amt_i(dec.amt), .y_o(sh_y)
  );

  assign wr_en = (dec.kind == K_ALU) || (dec.kind == K_SHIFT);
  assign res   = (dec.kind == K_SHIFT) ? sh_y : alu_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_idx_o   <= '0;
      wb_data_o  <= '0;
      illegal_o  <= 1'b0;
    end else begin
      wb_valid_o <= wr_en;
      illegal_o  <= (dec.kind == K_ILL);
      if (wr_en) begin
        wb_idx_o  <= rd_idx;
        wb_data_o <= res;
      end
    end
  end
endmodule

// File: rtl/reg_alu_unit_chk.sv
module reg_alu_unit_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_valid_i,
  input logic [15:0]      instr_i,
  input logic             wb_valid_o,
  input logic [IDX_W-1:0] wb_idx_o,
  input logic             illegal_o
);
  // R7
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[15:12] == 4'h6 && instr_i[11] && instr_i[11:8] != 4'hF)
    |=> (illegal_o && !wb_valid_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> (!wb_valid_o && !illegal_o));

  // R5
  shift_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[15:12] == 4'h7)
    |=> (wb_valid_o && wb_idx_o == $past(instr_i[8 +: IDX_W])));

  // R8
  foreign_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[15:13] != 3'b011)
    |=> (!wb_valid_o && !illegal_o));

  // R2
  alu_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[15:12] == 4'h6 && !instr_i[11])
    |=> (wb_valid_o && wb_idx_o == $past(instr_i[IDX_W-1:0])));
endmodule

bind reg_alu_unit reg_alu_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .instr_valid_i, .instr_i, .wb_valid_o, .wb_idx_o, .illegal_o
);

// File: tb/reg_alu_unit_bench.sv
`timescale 1ns/1ps
module reg_alu_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv = 1'b0;
  logic [15:0] ins = '0;
  logic        le = 1'b0;
  logic [2:0]  li = '0;
  logic [31:0] ld = '0;
  logic        wbv, ill;
  logic [2:0]  wbi;
  logic [31:0] wbd;

  int checks = 0, bad = 0;
  logic [31:0] mdl [8];

  always #2 clk = ~clk;

  reg_alu_unit u_reg_alu_unit (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(iv), .instr_i(ins),
    .ld_en_i(le), .ld_idx_i(li), .ld_data_i(ld),
    .wb_valid_o(wbv), .wb_idx_o(wbi), .wb_data_o(wbd), .illegal_o(ill)
  );

  function automatic logic [31:0] ref_shift(logic [31:0] a, logic [7:0] ss);
    int amt = $signed(ss);
    if (amt >= 32 || amt <= -32) return 32'h0;
    if (amt >= 0) return a << amt;
    return a >> (-amt);
  endfunction

  function automatic string tag_of(logic [15:0] x);
    if (x[15:12] == 4'h7) return (x[7] ? "R6" : "R5");
    if (x[15:12] != 4'h6 || x[11:8] == 4'hF) return "R8";
    if (x[11]) return "R7";
    case (x[11:8])
      4'h0, 4'h1, 4'h2: return "R2";
      4'h7:             return "R4";
      default:          return "R3";
    endcase
  endfunction

  // drives one cycle at a negedge, checks at the next negedge
  task automatic step(input logic v, input logic [15:0] x,
                      input logic l_en, input logic [2:0] l_idx, input logic [31:0] l_d,
                      input string tag);
    logic ev, eil; logic [2:0] ei; logic [31:0] ed;
    logic [31:0] dv, sv;
    ev = 0; eil = 0; ei = 0; ed = 0;
    iv = v; ins = x; le = l_en; li = l_idx; ld = l_d;
    if (v) begin
      if (x[15:12] == 4'h6 && !x[11]) begin
        ev = 1; ei = x[2:0]; dv = mdl[x[2:0]]; sv = mdl[x[6:4]];
        case (x[10:8])
          3'd0: ed = sv;
          3'd1: ed = dv + sv;
          3'd2: ed = dv & sv;
          3'd3: ed = dv + 1;
          3'd4: ed = dv + 4;
          3'd5: ed = dv - 1;
          3'd6: ed = dv - 4;
          default: ed = ~dv;
        endcase
      end else if (x[15:12] == 4'h6 && x[11:8] != 4'hF) begin
        eil = 1;
      end else if (x[15:12] == 4'h7) begin
        ev = 1; ei = x[10:8]; ed = ref_shift(mdl[x[10:8]], x[7:0]);
      end
    end
    if (l_en) mdl[l_idx] = l_d;
    if (ev) mdl[ei] = ed;
    @(negedge clk);
    checks++;
    if (wbv !== ev || ill !== eil || (ev && (wbi !== ei || wbd !== ed))) begin
      bad++;
      $display("FAIL %s instr=%h: got v=%b i=%0d d=%h ill=%b, want v=%b i=%0d d=%h ill=%b",
               tag, x, wbv, wbi, wbd, ill, ev, ei, ed, eil);
    end
    iv = 0; le = 0;
  endtask

  task automatic exec(input logic [15:0] x);
    step(1'b1, x, 1'b0, 3'd0, 32'h0, tag_of(x));
  endtask

  task automatic load(input logic [2:0] r, input logic [31:0] d);
    step(1'b0, 16'h0, 1'b1, r, d, "R10");
  endtask

  // read back r via mov r,r
  task automatic peek(input logic [2:0] r, input string tag);
    step(1'b1, {8'h60, 1'b0, r, 1'b0, r}, 1'b0, 3'd0, 32'h0, tag);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h1d2c3b4a);
    for (int i = 0; i < 8; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (wbv !== 1'b0 || ill !== 1'b0) begin
      bad++; $display("FAIL R1: outputs in reset v=%b ill=%b want 0 0", wbv, ill);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) peek(3'(i), "R1");

    // R2
    load(3'd1, 32'h1234_5678); load(3'd2, 32'h0F0F_F0F0);
    exec(16'h6012); exec(16'h6121); exec(16'h6213);
    // R3 wrap
    load(3'd3, 32'hFFFF_FFFF); exec(16'h6303);
    load(3'd4, 32'hFFFF_FFFE); exec(16'h6404);
    load(3'd5, 32'h0);         exec(16'h6505);
    load(3'd6, 32'h2);         exec(16'h6606);
    // R4
    exec(16'h6701);
    // R5 / R6
    load(3'd0, 32'h8000_0001);
    exec(16'h7000); exec(16'h7001); exec(16'h701F);
    load(3'd0, 32'hFFFF_FFFF); exec(16'h7020);
    load(3'd0, 32'hFFFF_FFFF); exec(16'h707F);
    load(3'd7, 32'h8000_0000); exec(16'h77FF); exec(16'h77E1);
    load(3'd7, 32'hFFFF_FFFF); exec(16'h77E0);
    load(3'd7, 32'hFFFF_FFFF); exec(16'h7780);
    // R7: no write
    load(3'd2, 32'hCAFE_F00D);
    exec(16'h6802); exec(16'h6E02); peek(3'd2, "R7");
    // R8
    exec(16'h6F02); exec(16'h1232); exec(16'hF000); exec(16'h8002); peek(3'd2, "R8");
    // R9: idle cycle
    step(1'b0, 16'h6303, 1'b0, 3'd0, 32'h0, "R9");
    // R10: same-register collision, instruction wins
    step(1'b1, 16'h6305, 1'b1, 3'd5, 32'h5555_5555, "R10");
    peek(3'd5, "R10");
    step(1'b1, 16'h6305, 1'b1, 3'd6, 32'h6666_6666, "R10");
    peek(3'd6, "R10");

    for (int n = 0; n < 600; n++) begin
      logic [15:0] x; int c;
      c = $urandom_range(0, 99);
      if (c < 55)      x = {4'h6, 1'b0, 3'($urandom_range(0, 7)), 1'b0, 3'($urandom), 1'b0, 3'($urandom)};
      else if (c < 80) x = {4'h7, 1'b0, 3'($urandom), 8'($urandom)};
      else if (c < 87) x = {4'h6, 4'($urandom_range(8, 15)), 8'($urandom)};
      else             x = 16'($urandom);
      step($urandom_range(0, 9) != 0, x, $urandom_range(0, 3) == 0, 3'($urandom), $urandom,
           tag_of(x));
    end
    for (int i = 0; i < 8; i++) peek(3'(i), "R10");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule